// File: doc/BRIEF.md
# Grouped Interrupt Expander with Per-Group Acknowledge

This block fans many peripheral interrupt lines into a small number of CPU interrupt inputs. The lines are arranged in groups of eight. Each line owns a pending flag and an enable bit. Each group owns an acknowledge latch. When a group has at least one line that is both enabled and pending, and its latch is open, the group is forwarded to the CPU side. Forwarding closes the latch, and the latch stays closed until software opens it again. Software opens it by writing a one to the group's bit in the acknowledge register, or by writing zero to the whole enable register of that group.

On the CPU side, each group has a core flag, a core enable mask bit, and a shared global mask. The block raises `cpu_irq` when some group has both its core flag and its core enable set and the global mask is clear. When the CPU accepts the interrupt, the block clears the winning core flag and the serviced line's pending flag, and sets the global mask so that no interrupt can nest. It then reports the group index and line index. A return pulse clears the global mask.

Software reaches the block through a word-wide register port. Writes take effect at the next clock edge. Reads have no side effects and return registered data. The address map is: enable of group g at g; pending flags of group g at NGRP+g (read only); acknowledge at 2·NGRP (write 1 to clear); core enable mask at 2·NGRP+1; core flags at 2·NGRP+2 (read only); global mask at 2·NGRP+3, bit 0. With the defaults these addresses are 0–11, 12–23, 24, 25, 26 and 27. Any other address reads as zero.

Top module: `grp_irq_expander`

## Requirements
- R1: A pulse on `periph_irq[8*g+l]` sets bit l of group g's pending flags at the next edge, whether or not that line is enabled. Software reads the flags at address NGRP+g.
- R2: An accepted take clears the pending flag of the serviced line. If a new pulse arrives on that same line in the same cycle, the flag stays set.
- R3: A group with an enabled pending line and an open latch is forwarded at the next edge. Forwarding sets the group's acknowledge bit (address 2·NGRP) and its core flag (address 2·NGRP+2) together. While the acknowledge bit is set, that group raises no further core flag.
- R4: Writing 1 to bit g of the acknowledge register clears that bit. Writing 0 leaves the bit unchanged. Hardware never clears an acknowledge bit in any other way than R4 and R5.
- R5: Writing all zeros to group g's enable register also clears acknowledge bit g. A write that leaves any enable bit set, for example one that clears a single bit, leaves the acknowledge bit unchanged. A disabled line is never forwarded.
- R6: `cpu_irq` is high exactly when some group has both its core flag and its core enable bit set and the global mask is 0. A take is accepted when `cpu_take` is high while `cpu_irq` is high.
- R7: An accepted take sets the global mask and clears the winning group's core flag. A `cpu_rti` pulse clears the global mask. If a take and `cpu_rti` occur in the same cycle, the take wins. Software may also write the global mask at address 2·NGRP+3.
- R8: Among the groups with both core flag and core enable set, the lowest-numbered group wins. Within that group, the lowest-numbered line that is both enabled and pending wins. One cycle after an accepted take, `take_valid` pulses with the 4-bit `take_grp` and the 3-bit `take_line`.
- R9: After reset, all flags, enables, acknowledge bits, core flags and the core mask are 0, the global mask is 1, and `cpu_irq` and `take_valid` are low.
- R10: A register write is visible from the next edge. `reg_rdata` is registered and returns the state addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_irq | input | NGRP*NLINE | Peripheral interrupt pulses, line l of group g at bit 8g+l |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | DW | Registered read data |
| cpu_take | input | 1 | CPU accepts the interrupt |
| cpu_rti | input | 1 | Return-from-interrupt pulse |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| take_valid | output | 1 | Service report valid |
| take_grp | output | GW | Serviced group index |
| take_line | output | LW | Serviced line index |

## Verification
A peripheral pulse shows up in the flag register at the next edge. It takes one more edge to reach the acknowledge bit, the core flag and `cpu_irq`. The results of a take, which are the report, the mask and the flag clearing, appear one edge after the take is sampled. A read returns its data one edge after its address is presented. The bench drives all inputs on the falling edge. A behavioural model steps at every rising edge, and its values are compared with the registered outputs on the next falling edge. Each directed check waits out the edges listed above before it reads, so every result is sampled in the cycle where it is due.

// File: rtl/gie_pkg.sv
package gie_pkg;
  // Register offsets derived from the group count.
  function automatic int ofs_flag(input int ngrp);
    return ngrp;
  endfunction
  function automatic int ofs_ack(input int ngrp);
    return 2 * ngrp;
  endfunction
  function automatic int ofs_ier(input int ngrp);
    return 2 * ngrp + 1;
  endfunction
  function automatic int ofs_cflag(input int ngrp);
    return 2 * ngrp + 2;
  endfunction
  function automatic int ofs_gmask(input int ngrp);
    return 2 * ngrp + 3;
  endfunction

  // Decoded register write strobes that are shared by all groups.
  typedef struct packed {
    logic ack_w1c;
    logic ier_wr;
    logic gm_wr;
  } gie_wr_t;
endpackage

// File: rtl/gie_line_group.sv
module gie_line_group #(
  parameter int NLINE = 8,
  parameter int LW    = $clog2(NLINE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLINE-1:0] irq_in,
  input  logic             en_wr,
  input  logic             ack_w1c,
  input  logic [NLINE-1:0] wdata,
  input  logic             take_sel,
  output logic [NLINE-1:0] flag_q,
  output logic [NLINE-1:0] en_q,
  output logic             ack_q,
  output logic             fwd,
  output logic [LW-1:0]    pick_idx
);
  logic [NLINE-1:0] act;
  logic [NLINE-1:0] clr;
  logic             pick_any;
  logic             ack_rel;

  always_comb begin
    act      = flag_q & en_q;
    fwd      = (|act) && !ack_q;
    pick_idx = '0;
    pick_any = 1'b0;
    for (int i = NLINE - 1; i >= 0; i--) begin
      if (act[i]) begin
        pick_idx = LW'(i);
        pick_any = 1'b1;
      end
    end
    clr = '0;
    if (take_sel && pick_any) clr[pick_idx] = 1'b1;
    ack_rel = ack_w1c || (en_wr && (wdata == '0));
  end

  // Per-line pending flags: a new pulse wins over the service clear.
  for (genvar l = 0; l < NLINE; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) flag_q[l] <= 1'b0;
      else     flag_q[l] <= (flag_q[l] && !clr[l]) || irq_in[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      ack_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= wdata;
      if (fwd)          ack_q <= 1'b1;
      else if (ack_rel) ack_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gie_core_arb.sv
module gie_core_arb #(
  parameter int NGRP = 12,
  parameter int GW   = $clog2(NGRP)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NGRP-1:0] fwd,
  input  logic            ier_wr,
  input  logic            gm_wr,
  input  logic [NGRP-1:0] ier_wdata,
  input  logic            gm_wdata,
  input  logic            cpu_take,
  input  logic            cpu_rti,
  output logic [NGRP-1:0] cflag_q,
  output logic [NGRP-1:0] ier_q,
  output logic            gm_q,
  output logic            cpu_irq,
  output logic            accept,
  output logic [NGRP-1:0] win_sel,
  output logic [GW-1:0]   win_idx
);
  logic [NGRP-1:0] live;
  logic [NGRP-1:0] cflag_n;
  logic [NGRP-1:0] ier_n;
  logic            gm_n;
  logic            irq_n;

  always_comb begin
    live    = cflag_q & ier_q;
    win_idx = '0;
    win_sel = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (live[g]) begin
        win_idx = GW'(g);
        win_sel = '0;
        win_sel[g] = 1'b1;
      end
    end
    accept = cpu_take && cpu_irq;
    ier_n  = ier_wr ? ier_wdata : ier_q;
    if (accept)       gm_n = 1'b1;
    else if (cpu_rti) gm_n = 1'b0;
    else if (gm_wr)   gm_n = gm_wdata;
    else              gm_n = gm_q;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_cf
    assign cflag_n[g] = (cflag_q[g] && !(accept && win_sel[g])) || fwd[g];
  end

  // The request register is loaded from next state, so it always matches the held state.
  assign irq_n = (|(cflag_n & ier_n)) && !gm_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cflag_q <= '0;
      ier_q   <= '0;
      gm_q    <= 1'b1;
      cpu_irq <= 1'b0;
    end else begin
      cflag_q <= cflag_n;
      ier_q   <= ier_n;
      gm_q    <= gm_n;
      cpu_irq <= irq_n;
    end
  end
endmodule

// File: rtl/grp_irq_expander.sv
module grp_irq_expander #(
  parameter int NGRP  = 12,
  parameter int NLINE = 8,
  parameter int DW    = (NGRP > NLINE) ? NGRP : NLINE,
  parameter int AW    = $clog2(2 * NGRP + 4),
  parameter int GW    = $clog2(NGRP),
  parameter int LW    = $clog2(NLINE)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NGRP*NLINE-1:0] periph_irq,
  input  logic [AW-1:0]         reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  input  logic                  reg_we,
  output logic [DW-1:0]         reg_rdata,
  input  logic                  cpu_take,
  input  logic                  cpu_rti,
  output logic                  cpu_irq,
  output logic                  take_valid,
  output logic [GW-1:0]         take_grp,
  output logic [LW-1:0]         take_line
);
  import gie_pkg::*;

  localparam int A_FLAG = ofs_flag(NGRP);
  localparam int A_ACK  = ofs_ack(NGRP);
  localparam int A_IER  = ofs_ier(NGRP);
  localparam int A_CF   = ofs_cflag(NGRP);
  localparam int A_GM   = ofs_gmask(NGRP);

  gie_wr_t           wr;
  logic [NGRP-1:0]   en_wr;
  logic [NGRP-1:0]   fwd;
  logic [NGRP-1:0]   ack_all;
  logic [NGRP-1:0]   cflag_all;
  logic [NGRP-1:0]   ier_all;
  logic [NGRP-1:0]   win_sel;
  logic [GW-1:0]     win_idx;
  logic              gm_now;
  logic              accept;
  logic [NLINE-1:0]  flag_a [NGRP];
  logic [NLINE-1:0]  en_a   [NGRP];
  logic [LW-1:0]     pick_a [NGRP];
  logic [NGRP*NLINE-1:0] flag_all;
  logic [DW-1:0]     rd_n;
  logic [LW-1:0]     line_n;

  always_comb begin
    wr.ack_w1c = reg_we && (reg_addr == AW'(A_ACK));
    wr.ier_wr  = reg_we && (reg_addr == AW'(A_IER));
    wr.gm_wr   = reg_we && (reg_addr == AW'(A_GM));
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign en_wr[g] = reg_we && (reg_addr == AW'(g));
    assign flag_all[g*NLINE +: NLINE] = flag_a[g];

    gie_line_group #(.NLINE(NLINE), .LW(LW)) u_grp (
      .clk      (clk),
      .rst      (rst),
      .irq_in   (periph_irq[g*NLINE +: NLINE]),
      .en_wr    (en_wr[g]),
      .ack_w1c  (wr.ack_w1c && reg_wdata[g]),
      .wdata    (reg_wdata[NLINE-1:0]),
      .take_sel (accept && win_sel[g]),
      .flag_q   (flag_a[g]),
      .en_q     (en_a[g]),
      .ack_q    (ack_all[g]),
      .fwd      (fwd[g]),
      .pick_idx (pick_a[g])
    );
  end

  gie_core_arb #(.NGRP(NGRP), .GW(GW)) u_core (
    .clk       (clk),
    .rst       (rst),
    .fwd       (fwd),
    .ier_wr    (wr.ier_wr),
    .gm_wr     (wr.gm_wr),
    .ier_wdata (reg_wdata[NGRP-1:0]),
    .gm_wdata  (reg_wdata[0]),
    .cpu_take  (cpu_take),
    .cpu_rti   (cpu_rti),
    .cflag_q   (cflag_all),
    .ier_q     (ier_all),
    .gm_q      (gm_now),
    .cpu_irq   (cpu_irq),
    .accept    (accept),
    .win_sel   (win_sel),
    .win_idx   (win_idx)
  );

  always_comb begin
    rd_n   = '0;
    line_n = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (reg_addr == AW'(g))          rd_n[NLINE-1:0] = en_a[g];
      if (reg_addr == AW'(A_FLAG + g)) rd_n[NLINE-1:0] = flag_a[g];
      if (win_idx == GW'(g))           line_n = pick_a[g];
    end
    if (reg_addr == AW'(A_ACK)) rd_n[NGRP-1:0] = ack_all;
    if (reg_addr == AW'(A_IER)) rd_n[NGRP-1:0] = ier_all;
    if (reg_addr == AW'(A_CF))  rd_n[NGRP-1:0] = cflag_all;
    if (reg_addr == AW'(A_GM))  rd_n[0]        = gm_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      take_valid <= 1'b0;
      take_grp   <= '0;
      take_line  <= '0;
    end else begin
      reg_rdata  <= rd_n;
      take_valid <= accept;
      take_grp   <= win_idx;
      take_line  <= line_n;
    end
  end
endmodule

// File: rtl/gie_checker.sv
module gie_checker #(
  parameter int NGRP  = 12,
  parameter int NLINE = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NGRP*NLINE-1:0] periph_irq,
  input logic                  reg_we,
  input logic                  cpu_take,
  input logic                  cpu_irq,
  input logic                  take_valid,
  input logic [NGRP-1:0]       ack_all,
  input logic [NGRP-1:0]       cflag_all,
  input logic                  gm_now,
  input logic [NGRP*NLINE-1:0] flag_all
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_flag_capture_R1: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((flag_all & $past(periph_irq)) == $past(periph_irq)));

  assert_ack_with_core_flag_R3: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((ack_all & ~$past(ack_all) & ~cflag_all) == '0));

  assert_ack_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(reg_we)) |-> (($past(ack_all) & ~ack_all) == '0));

  assert_irq_unmasked_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> !gm_now);

  assert_take_masks_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_take && cpu_irq) |=> gm_now);

  assert_take_report_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_take && cpu_irq) |=> take_valid);

  assert_no_spurious_report_R8: assert property (@(posedge clk) disable iff (rst)
    !(cpu_take && cpu_irq) |=> !take_valid);
endmodule

bind grp_irq_expander gie_checker #(.NGRP(NGRP), .NLINE(NLINE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .periph_irq (periph_irq),
  .reg_we     (reg_we),
  .cpu_take   (cpu_take),
  .cpu_irq    (cpu_irq),
  .take_valid (take_valid),
  .ack_all    (ack_all),
  .cflag_all  (cflag_all),
  .gm_now     (gm_now),
  .flag_all   (flag_all)
);

// File: tb/test_grp_irq_expander.sv
module test_grp_irq_expander;
  localparam int G  = 12;
  localparam int L  = 8;
  localparam int DW = 12;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [G*L-1:0] periph_irq = '0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic          reg_we = 1'b0;
  logic [DW-1:0] reg_rdata;
  logic          cpu_take = 1'b0;
  logic          cpu_rti = 1'b0;
  logic          cpu_irq;
  logic          take_valid;
  logic [3:0]    take_grp;
  logic [2:0]    take_line;

  int n_chk = 0;
  int n_bad = 0;
  bit run = 0;

  always #5 clk = ~clk;

  grp_irq_expander i_grp_irq_expander (
    .clk(clk), .rst(rst), .periph_irq(periph_irq), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .cpu_take(cpu_take), .cpu_rti(cpu_rti), .cpu_irq(cpu_irq),
    .take_valid(take_valid), .take_grp(take_grp), .take_line(take_line)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [7:0]  mf [G];
  logic [7:0]  me [G];
  logic [11:0] mack, mcf, mier, mrd;
  logic        mgm, mirq, mtv;
  int          mtg, mtl, maddr;

  function automatic logic [11:0] mread(input int a);
    if (a < G)             return {4'h0, me[a]};
    else if (a < 2 * G)    return {4'h0, mf[a - G]};
    else if (a == 2 * G)   return mack;
    else if (a == 2*G + 1) return mier;
    else if (a == 2*G + 2) return mcf;
    else if (a == 2*G + 3) return {11'h0, mgm};
    return '0;
  endfunction

  function automatic string rtag(input int a);
    if (a < G)             return "R5";
    else if (a < 2 * G)    return "R1";
    else if (a == 2 * G)   return "R4";
    else if (a == 2*G + 2) return "R3";
    else if (a == 2*G + 3) return "R7";
    return "R10";
  endfunction

  always @(posedge clk) begin : model
    bit acc;
    int wg, wl;
    bit fw [G];
    if (rst) begin
      for (int g = 0; g < G; g++) begin mf[g] = '0; me[g] = '0; end
      mack = '0; mcf = '0; mier = '0; mgm = 1'b1; mirq = 1'b0;
      mtv = 1'b0; mtg = 0; mtl = 0; mrd = '0; maddr = 0;
    end else begin
      maddr = int'(reg_addr);
      mrd = mread(maddr);
      acc = cpu_take && mirq;
      wg = -1; wl = -1;
      if (acc) begin
        for (int g = G - 1; g >= 0; g--) if (mcf[g] && mier[g]) wg = g;
        for (int l = L - 1; l >= 0; l--) if (mf[wg][l] && me[wg][l]) wl = l;
      end
      for (int g = 0; g < G; g++) fw[g] = ((mf[g] & me[g]) != 0) && !mack[g];
      for (int g = 0; g < G; g++) begin
        if (g == wg && wl >= 0) mf[g][wl] = 1'b0;
        mf[g] = mf[g] | periph_irq[g*L +: L];
        if (fw[g]) mack[g] = 1'b1;
        else if (reg_we && reg_addr == 5'(2*G) && reg_wdata[g]) mack[g] = 1'b0;
        else if (reg_we && reg_addr == 5'(g) && reg_wdata[7:0] == 0) mack[g] = 1'b0;
        if (reg_we && reg_addr == 5'(g)) me[g] = reg_wdata[7:0];
        if (g == wg) mcf[g] = 1'b0;
        if (fw[g]) mcf[g] = 1'b1;
      end
      if (reg_we && reg_addr == 5'(2*G + 1)) mier = reg_wdata;
      if (acc) mgm = 1'b1;
      else if (cpu_rti) mgm = 1'b0;
      else if (reg_we && reg_addr == 5'(2*G + 3)) mgm = reg_wdata[0];
      mirq = ((mcf & mier) != 0) && !mgm;
      mtv = acc;
      if (acc) begin mtg = wg; mtl = (wl >= 0) ? wl : 0; end
    end
  end

  always @(negedge clk) begin
    if (run) begin
      check(cpu_irq == mirq, "R6", "cpu_irq", cpu_irq, mirq);
      check(take_valid == mtv, "R8", "take_valid", take_valid, mtv);
      if (mtv) begin
        check(take_grp == 4'(mtg), "R8", "take_grp", take_grp, mtg);
        check(take_line == 3'(mtl), "R8", "take_line", take_line, mtl);
      end
      check(reg_rdata == mrd, rtag(maddr), "reg_rdata", reg_rdata, mrd);
    end
  end

  // Stimulus helpers: each starts just after a falling edge.
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = 5'(a); reg_wdata = 12'(d); reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    reg_addr = 5'(a);
    @(negedge clk);
    check(reg_rdata == 12'(exp), req, $sformatf("read @%0d", a), reg_rdata, exp);
  endtask

  task automatic pulse(input int b);
    periph_irq[b] = 1'b1;
    @(negedge clk);
    periph_irq = '0;
  endtask

  task automatic take_chk(input int g, input int l, input string req);
    cpu_take = 1'b1;
    @(negedge clk);
    cpu_take = 1'b0;
    check(take_valid == 1'b1, req, "take_valid", take_valid, 1);
    check(take_grp == 4'(g), req, "take_grp", take_grp, g);
    check(take_line == 3'(l), req, "take_line", take_line, l);
  endtask

  task automatic rti();
    cpu_rti = 1'b1;
    @(negedge clk);
    cpu_rti = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    run = 1;
    idle(1);
    // R9 reset state
    check(cpu_irq == 1'b0, "R9", "cpu_irq after reset", cpu_irq, 0);
    rd_chk(27, 1, "R9");
    rd_chk(24, 0, "R9");
    rd_chk(25, 0, "R9");
    // R10 write then read
    wr(25, 12'h00F);
    rd_chk(25, 12'h00F, "R10");
    wr(27, 0);
    rd_chk(27, 0, "R10");
    // R1 flag set with line disabled; no forwarding
    pulse(2*8 + 5);
    idle(2);
    rd_chk(14, 8'h20, "R1");
    rd_chk(24, 0, "R5");
    check(cpu_irq == 1'b0, "R6", "cpu_irq disabled line", cpu_irq, 0);
    // R3 forwarding after enable
    wr(2, 8'h60);
    idle(2);
    rd_chk(24, 12'h004, "R3");
    rd_chk(26, 12'h004, "R3");
    check(cpu_irq == 1'b1, "R6", "cpu_irq raised", cpu_irq, 1);
    take_chk(2, 5, "R8");
    check(cpu_irq == 1'b0, "R7", "cpu_irq after take", cpu_irq, 0);
    rd_chk(14, 0, "R2");
    rd_chk(27, 1, "R7");
    rd_chk(26, 0, "R7");
    // R3 hold-off while acknowledge is set
    pulse(2*8 + 5);
    idle(2);
    rd_chk(14, 8'h20, "R1");
    rd_chk(26, 0, "R3");
    rd_chk(24, 12'h004, "R4");
    rti();
    rd_chk(27, 0, "R7");
    check(cpu_irq == 1'b0, "R3", "no request while held", cpu_irq, 0);
    // R5 partial write keeps latch, zero write releases it
    wr(2, 8'h40);
    rd_chk(24, 12'h004, "R5");
    wr(2, 8'h00);
    rd_chk(24, 0, "R5");
    idle(2);
    rd_chk(26, 0, "R5");
    wr(2, 8'h20);
    idle(2);
    rd_chk(24, 12'h004, "R3");
    check(cpu_irq == 1'b1, "R6", "cpu_irq re-enabled", cpu_irq, 1);
    take_chk(2, 5, "R8");
    rti();
    // R4 write-one-to-clear
    wr(24, 0);
    rd_chk(24, 12'h004, "R4");
    wr(24, 12'h004);
    rd_chk(24, 0, "R4");
    // R8 priority across and within groups
    wr(1, 8'hFF);
    wr(3, 8'hFF);
    periph_irq[3*8 + 1] = 1'b1;
    periph_irq[1*8 + 6] = 1'b1;
    periph_irq[1*8 + 2] = 1'b1;
    idle(1);
    periph_irq = '0;
    idle(2);
    rd_chk(26, 12'h00A, "R3");
    take_chk(1, 2, "R8");
    rti();
    check(cpu_irq == 1'b1, "R6", "second group pending", cpu_irq, 1);
    take_chk(3, 1, "R8");
    rti();
    // R2 pulse during service clear keeps the flag
    wr(24, 12'h002);
    idle(2);
    check(cpu_irq == 1'b1, "R3", "group 1 forwarded again", cpu_irq, 1);
    periph_irq[1*8 + 6] = 1'b1;
    take_chk(1, 6, "R8");
    periph_irq = '0;
    rd_chk(13, 8'h40, "R2");
    rti();
    // R7 take and return in the same cycle: take wins
    wr(24, 12'h002);
    idle(2);
    cpu_take = 1'b1; cpu_rti = 1'b1;
    idle(1);
    cpu_take = 1'b0; cpu_rti = 1'b0;
    rd_chk(27, 1, "R7");
    rti();
    // Mixed traffic compared against the model every cycle
    for (int c = 0; c < 600; c++) begin
      periph_irq = '0;
      if ($urandom % 6 == 0) periph_irq[$urandom % (G*L)] = 1'b1;
      reg_we = 1'b0;
      case ($urandom % 10)
        0: begin reg_we = 1'b1; reg_addr = 5'($urandom % 4); reg_wdata = 12'($urandom % 4 == 0 ? 0 : $urandom); end
        1: begin reg_we = 1'b1; reg_addr = 5'(24); reg_wdata = 12'($urandom); end
        2: begin reg_we = 1'b1; reg_addr = 5'(25); reg_wdata = 12'($urandom); end
        3: begin reg_we = 1'b1; reg_addr = 5'(27); reg_wdata = 12'($urandom % 2); end
        default: reg_addr = 5'($urandom % 28);
      endcase
      cpu_take = ($urandom % 3 == 0);
      cpu_rti = ($urandom % 5 == 0);
      @(negedge clk);
    end
    periph_irq = '0; reg_we = 1'b0; cpu_take = 1'b0; cpu_rti = 1'b0;
    idle(3);
    run = 0;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule